// File: doc/BRIEF.md
# SPI Master Transmitter with Chip-Select Hold

This block is an SPI master transmitter for mode 0 with a fixed 8-bit frame. Software writes bytes into a one-entry holding register. The holding register feeds a shift register that drives MOSI, MSB first, and samples MISO back into a receive byte. The block has four active-low chip-select lines. A 2-bit select field picks the active line, and while a transfer is in progress only that line goes low.

Each chip select has its own keep-active bit, and that bit chooses one of two release policies. With the bit clear, the selected line is low only while the holding register or the shifter holds data, and it rises as soon as both are empty. With the bit set, the line stays low between bytes. It is released only when a last-transfer flag is set and both the holding register and the shifter are empty. The flag can be raised by a control strobe or by a flag bit that travels with a data write. It clears when the line is released.

Register writes use a plain write port with a 2-bit address: 0 is data, 1 is control and 2 is configuration. The configuration word also carries the SCK divider.

Top module: `spi_chold_master`

## Requirements
- R1: A data write (address 0, byte in bits 7:0) is accepted only when the holding register is empty. A data write that arrives while the holding register is full is dropped and has no effect on what is shifted out.
- R2: When the shifter is idle and the holding register is full, the byte moves into the shifter on the next clock. When a byte finishes and the holding register is full, the next byte starts on the following clock with no idle SCK gap and no shifter-empty indication.
- R3: SCK idles low. Each SCK half period lasts divider+2 clocks, where the divider is configuration bits 11:8. MOSI carries the byte MSB first and changes only on falling SCK edges.
- R4: MISO is sampled on each rising SCK edge. After the eighth bit, the received byte appears on rx_data_o together with a one-clock rx_valid_o pulse.
- R5: With the keep-active bit of the selected line clear, the selected line is low exactly while the holding register or the shifter holds data.
- R6: With the keep-active bit set (configuration bit n for line n), the selected line stays low after data runs out, until the last-transfer flag is set.
- R7: With the keep-active bit set, the last-transfer flag is set either by a control write with bit 0 high, or by a data write with bit 8 high. The line is released once the flag is set and both registers are empty.
- R8: If the flag is set while new bytes keep reaching the holding register before the shifter drains, the line stays low until the shifter is actually empty.
- R9: With the keep-active bit clear, a last-transfer request from either source is ignored and is not remembered after the keep-active bit is later set.
- R10: The last-transfer flag clears when the held line is released, so the next held transfer stays low until a new request arrives.
- R11: A control write with bit 1 high loads the select field from bits 3:2. Only the selected line of the four ever goes low.
- R12: After reset all chip selects are high, SCK is low, and hold_empty_o and shift_empty_o are both 1. These status outputs report the occupancy of the holding register and the shifter separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 data, 1 control, 2 configuration |
| wr_data_i | input | 16 | Write data |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Active-low chip selects |
| hold_empty_o | output | 1 | Holding register empty |
| shift_empty_o | output | 1 | Shifter idle |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse when rx_data_o updates |

## Verification
The assertions on the chip-select policy assume that the keep-active bits and the select field stay unchanged while a line is driven low. Where that cannot be guaranteed, the properties themselves test for stability. The timing checks assume that the divider is not rewritten during a byte. The stimulus respects both assumptions: it writes configuration and select only after the model reports both registers empty. A loopback from MOSI to MISO makes the expected receive byte equal to the byte that was sent.

// File: rtl/spi_chold_pkg.sv
package spi_chold_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;

  localparam int unsigned CTRL_LAST_BIT     = 0;
  localparam int unsigned CTRL_SEL_LOAD_BIT = 1;
  localparam int unsigned CTRL_SEL_LSB      = 2;
  localparam int unsigned DATA_LAST_BIT     = 8;
  localparam int unsigned CFG_DIV_LSB       = 8;
endpackage

// File: rtl/spi_chold_txbuf.sv
module spi_chold_txbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic         accept_o,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign accept_o = wr_i & ~full_q;
  assign full_o   = full_q;
  assign data_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (accept_o) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end
    end
  end

  // R1
  wr_full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_q && !take_i) |=> ($stable(data_q) && full_q));
endmodule

// File: rtl/spi_chold_shifter.sv
module spi_chold_shifter #(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hold_full_i,
  input  logic [W-1:0]     hold_data_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [W-1:0]     rx_data_o,
  output logic             rx_valid_o
);
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam int unsigned BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(W - 1);

  logic             busy_q, ph_q, rx_valid_q;
  logic [CNT_W-1:0] cnt_q, half_last;
  logic [BIT_W-1:0] bit_q;
  logic [W-1:0]     sh_q, rx_sh_q, rx_q;
  logic             edge_tick, frame_end;

  // half period = div + 2 clocks
  assign half_last = CNT_W'(div_i) + CNT_W'(1);
  assign edge_tick = busy_q && (cnt_q == half_last);
  assign frame_end = edge_tick && ph_q && (bit_q == BIT_LAST);
  assign take_o    = hold_full_i && (!busy_q || frame_end);

  assign busy_o     = busy_q;
  assign sck_o      = ph_q;
  assign mosi_o     = busy_q & sh_q[W-1];
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      cnt_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      rx_sh_q    <= '0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= frame_end;
      if (frame_end) rx_q <= rx_sh_q;
      if (take_o) begin
        busy_q <= 1'b1;
        sh_q   <= hold_data_i;
        cnt_q  <= '0;
        ph_q   <= 1'b0;
        bit_q  <= '0;
      end else if (frame_end) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (edge_tick) begin
          cnt_q <= '0;
          if (!ph_q) begin
            ph_q    <= 1'b1;
            rx_sh_q <= {rx_sh_q[W-2:0], miso_i};
          end else begin
            ph_q  <= 1'b0;
            bit_q <= bit_q + BIT_W'(1);
            sh_q  <= {sh_q[W-2:0], 1'b0};
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_o);
  // R3
  sck_half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !edge_tick) |=> $stable(sck_o));
  // R2
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && hold_full_i) |=> busy_o);
  // R4
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(busy_o));
endmodule

// File: rtl/spi_chold_csctl.sv
module spi_chold_csctl #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     keep_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             last_req_i,
  input  logic             busy_i,
  input  logic             full_i,
  output logic [N-1:0]     cs_no
);
  logic hold_q, last_q;
  logic keep_sel, cs_on, release_w, hold_d, last_d;

  assign keep_sel  = keep_i[sel_i];
  assign cs_on     = busy_i | full_i | hold_q;
  assign release_w = last_q & ~busy_i & ~full_i;
  assign hold_d    = keep_sel & cs_on & ~release_w;

  always_comb begin
    last_d = last_q;
    if (release_w || !keep_sel) last_d = 1'b0;
    if (last_req_i && keep_sel) last_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      last_q <= last_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_cs
    assign cs_no[i] = ~(cs_on && (sel_i == SEL_W'(i)));
  end

  // R11
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R5
  plain_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!keep_sel && $stable(keep_i) && $stable(sel_i) && !busy_i && !full_i) |-> (&cs_no));
  // R6
  held_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_sel && !(&cs_no) && !last_q) |=> (!(&cs_no) || !$stable(keep_i) || !$stable(sel_i)));
  // R9
  last_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_sel |=> !last_q);
  // R10
  last_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_w && !last_req_i) |=> !last_q);
endmodule

// File: rtl/spi_chold_master.sv
module spi_chold_master
  import spi_chold_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned BUS_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [BUS_W-1:0]   wr_data_i,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_CS-1:0]  cs_no,
  output logic               hold_empty_o,
  output logic               shift_empty_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o
);
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic               wr_data_sel, wr_ctrl_sel, wr_cfg_sel;
  logic [NUM_CS-1:0]  keep_q;
  logic [SEL_W-1:0]   sel_q;
  logic [DIV_W-1:0]   div_q;
  logic               hold_accept, hold_full, take, busy, last_req;
  logic [FRAME_W-1:0] hold_data;

  assign wr_data_sel = wr_en_i && (wr_addr_i == ADDR_DATA);
  assign wr_ctrl_sel = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_cfg_sel  = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign last_req    = (wr_ctrl_sel && wr_data_i[CTRL_LAST_BIT]) ||
                       (hold_accept && wr_data_i[DATA_LAST_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q <= '0;
      sel_q  <= '0;
      div_q  <= '0;
    end else begin
      if (wr_cfg_sel) begin
        keep_q <= wr_data_i[NUM_CS-1:0];
        div_q  <= wr_data_i[CFG_DIV_LSB +: DIV_W];
      end
      if (wr_ctrl_sel && wr_data_i[CTRL_SEL_LOAD_BIT])
        sel_q <= wr_data_i[CTRL_SEL_LSB +: SEL_W];
    end
  end

  spi_chold_txbuf #(.W(FRAME_W)) u_txbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_data_sel),
    .wr_data_i (wr_data_i[FRAME_W-1:0]),
    .take_i    (take),
    .accept_o  (hold_accept),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  spi_chold_shifter #(.W(FRAME_W), .DIV_W(DIV_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_i       (div_q),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .busy_o      (busy),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o)
  );

  spi_chold_csctl #(.N(NUM_CS), .SEL_W(SEL_W)) u_csctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .keep_i     (keep_q),
    .sel_i      (sel_q),
    .last_req_i (last_req),
    .busy_i     (busy),
    .full_i     (hold_full),
    .cs_no      (cs_no)
  );

  assign hold_empty_o  = ~hold_full;
  assign shift_empty_o = ~busy;

  // R12
  status_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_empty_o && shift_empty_o) |-> !sck_o);
endmodule

// File: tb/spi_chold_master_tb.sv
module spi_chold_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;
  logic        hold_empty, shift_empty, rx_valid;
  logic [7:0]  rx_data;

  always #4 clk = ~clk;
  assign miso = mosi;

  spi_chold_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .cs_no(cs_n), .hold_empty_o(hold_empty), .shift_empty_o(shift_empty),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural reference state
  bit         m_full, m_busy, m_hold, m_last, m_rxv;
  int         m_tick, m_sel, m_div;
  logic [7:0] m_thr, m_sh, m_rx;
  logic [3:0] m_keep;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_hold = 0; m_last = 0; m_rxv = 0;
      m_tick = 0; m_sel = 0; m_div = 0; m_thr = 0; m_sh = 0; m_rx = 0; m_keep = 0;
    end else begin : step
      int h;
      bit ks, acc, setl, con, rel, n_hold, n_last;
      h = m_div + 2;
      ks = m_keep[m_sel];
      acc = wr_en && wr_addr == 2'd0 && !m_full;
      setl = ks && ((wr_en && wr_addr == 2'd1 && wr_data[0]) || (acc && wr_data[8]));
      con = m_busy || m_full || m_hold;
      rel = m_last && !m_full && !m_busy;
      n_hold = ks && con && !rel;
      n_last = setl ? 1'b1 : ((rel || !ks) ? 1'b0 : m_last);
      m_rxv = 0;
      if (m_busy) begin
        if (m_tick == 16*h - 1) begin
          m_rxv = 1; m_rx = m_sh;
          if (m_full) begin m_sh = m_thr; m_tick = 0; m_full = 0; end
          else m_busy = 0;
        end else m_tick++;
      end else if (m_full) begin
        m_busy = 1; m_tick = 0; m_sh = m_thr; m_full = 0;
      end
      if (acc) begin m_full = 1; m_thr = wr_data[7:0]; end
      m_hold = n_hold; m_last = n_last;
      if (wr_en && wr_addr == 2'd2) begin m_keep = wr_data[3:0]; m_div = int'(wr_data[11:8]); end
      if (wr_en && wr_addr == 2'd1 && wr_data[1]) m_sel = int'(wr_data[3:2]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin : cmp
      int h;
      logic [3:0] e_cs;
      bit e_sck, e_mosi;
      h = m_div + 2;
      e_cs = 4'hF;
      if (m_busy || m_full || m_hold) e_cs[m_sel] = 1'b0;
      e_sck = m_busy ? bit'((m_tick / h) % 2) : 1'b0;
      e_mosi = m_busy ? m_sh[7 - m_tick/(2*h)] : 1'b0;
      chk(cs_n == e_cs, "R5 R6 R8 R11 cs_n", cs_n, e_cs);
      chk(sck == e_sck, "R3 sck", sck, e_sck);
      chk(mosi == e_mosi, "R3 mosi", mosi, e_mosi);
      chk({hold_empty, shift_empty} == {!m_full, !m_busy}, "R12 R1 R2 status",
          {hold_empty, shift_empty}, {!m_full, !m_busy});
      chk(rx_valid == m_rxv, "R4 rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_data == m_rx, "R4 rx_data", rx_data, m_rx);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int g = 0;
    while ((m_busy || m_full) && g < 20000) begin @(negedge clk); g++; end
    idle(3);
  endtask

  task automatic wait_hold_empty();
    int g = 0;
    while (!hold_empty && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    // R12 reset state
    chk(cs_n == 4'hF && !sck && hold_empty && shift_empty, "R12 reset",
        {cs_n, sck, hold_empty, shift_empty}, 7'h7B);
    rst_n = 1'b1;
    idle(2);

    // R3 single byte, fastest divider
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h00A5);
    wait_quiet();
    chk(cs_n == 4'hF, "R5 released", cs_n, 4'hF);

    // R1 second write while full is dropped
    wr(2'd0, 16'h003C);
    wr(2'd0, 16'h00C3);
    wait_quiet();
    chk(rx_data == 8'h3C, "R1 dropped write", rx_data, 8'h3C);

    // R2 streaming without gaps
    for (int i = 0; i < 3; i++) begin
      wait_hold_empty();
      wr(2'd0, 16'(8'h11 * (i + 1)));
    end
    wait_quiet();
    chk(rx_data == 8'h33, "R2 stream last byte", rx_data, 8'h33);

    // R9 last requests ignored with keep clear
    wr(2'd0, 16'h015A);
    wr(2'd1, 16'h0001);
    wait_quiet();
    wr(2'd2, 16'h0101);
    wr(2'd0, 16'h0011);
    wait_quiet();
    idle(10);
    chk(cs_n[0] == 1'b0, "R9 held after stale last", cs_n, 4'hE);

    // R7 control strobe ends hold
    wr(2'd1, 16'h0001);
    idle(3);
    chk(cs_n == 4'hF, "R7 ctrl release", cs_n, 4'hF);

    // R10 flag cleared, next transfer held again
    wr(2'd0, 16'h0022);
    wait_quiet();
    idle(5);
    chk(cs_n[0] == 1'b0, "R10 held again", cs_n, 4'hE);
    // R7 data-write flag
    wr(2'd0, 16'h0133);
    wait_quiet();
    chk(cs_n == 4'hF, "R7 data-write release", cs_n, 4'hF);

    // R8 flag set early, data keeps arriving
    wr(2'd2, 16'h010F);
    wr(2'd1, 16'h000A);
    wr(2'd0, 16'h0144);
    for (int i = 0; i < 3; i++) begin
      wait_hold_empty();
      chk(cs_n == 4'hB, "R8 still held", cs_n, 4'hB);
      wr(2'd0, 16'(8'h50 + i));
    end
    wait_quiet();
    chk(cs_n == 4'hF, "R8 release after drain", cs_n, 4'hF);

    // R11 line 3 selected, its keep bit clear
    wr(2'd2, 16'h0104);
    wr(2'd1, 16'h000E);
    wr(2'd0, 16'h0077);
    idle(4);
    chk(cs_n == 4'h7, "R11 only line 3", cs_n, 4'h7);
    wait_quiet();
    chk(cs_n == 4'hF, "R11 R5 release", cs_n, 4'hF);

    // R6 held indefinitely on line 3, slower divider
    wr(2'd2, 16'h0208);
    wr(2'd0, 16'h0081);
    wait_quiet();
    idle(20);
    chk(cs_n == 4'h7, "R6 hold", cs_n, 4'h7);
    wr(2'd1, 16'h0001);
    idle(3);
    chk(cs_n == 4'hF, "R6 R7 release", cs_n, 4'hF);

    idle(5);
    done = 1;
    summary();
  end
endmodule